// File: doc/BRIEF.md
# Memory Strobe Timing Generator

This block shapes the three control strobes of an external parallel memory port for a single access: an address-latch strobe, a read-enable strobe and a write-enable strobe. Each strobe has its own programmable assert time and release time. The block also has a programmable total access length. All timing is counted in timing units from the start of the access. The block runs on one functional clock.

In asynchronous mode, one timing unit is one functional-clock cycle and the memory clock output stays low. In synchronous mode, the block produces a memory clock at the functional rate divided by (1 + divider field). One timing unit is then one memory-clock period, so every strobe edge lands on a memory-clock rising edge. A one-cycle start pulse launches an access and a one-cycle done pulse marks its end. The block samples all timing and mode fields at start, so a controller may set up the next access while the current one runs.

Top module: `mem_strobe_timer`

## Requirements
- R1: After reset, and whenever no access is running, ale_no, oe_no and we_no are high (strobes are active low), mclk_o is low and done_o is low.
- R2: A start_i pulse while idle begins an access, and the unit count starts at 0 in the first cycle after the start edge. A start_i pulse during an access is ignored and does not disturb its timing.
- R3: In asynchronous mode (sync_i=0), one timing unit equals one functional-clock cycle and div_i is ignored. A strobe is low in unit u exactly when on <= u < off for that strobe's fields.
- R4: In asynchronous mode, mclk_o stays low for the whole access.
- R5: In synchronous mode (sync_i=1), one timing unit lasts (1 + div_i) functional-clock cycles, with div_i from 0 to 3. Strobe on and off times are counted in those units.
- R6: In synchronous mode with ratio r = 1 + div_i >= 2, mclk_o is high in the first (r+1)/2 (integer) functional cycles of each unit and low in the rest. With r = 1, mclk_o follows the functional clock level during the access.
- R7: A strobe whose off field is less than or equal to its on field stays high for the whole access.
- R8: For a read (write_i=0), we_no stays high. For a write (write_i=1), oe_no stays high. ale_no follows its fields in both cases.
- R9: An access lasts max(cycle_i, 1) units. In the following cycle, done_o is high for exactly one cycle, all strobes are high and mclk_o is low.
- R10: Mode, direction, divider and all timing fields are sampled at the accepted start. Changes to them during an access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle access launch pulse |
| write_i | input | 1 | 1 = write access, 0 = read access |
| sync_i | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| div_i | input | DW (2) | Memory clock divider, ratio = 1 + div_i |
| ale_on_i | input | TW (5) | Address-latch strobe assert unit |
| ale_off_i | input | TW (5) | Address-latch strobe release unit |
| oe_on_i | input | TW (5) | Read-enable strobe assert unit |
| oe_off_i | input | TW (5) | Read-enable strobe release unit |
| we_on_i | input | TW (5) | Write-enable strobe assert unit |
| we_off_i | input | TW (5) | Write-enable strobe release unit |
| cycle_i | input | TW (5) | Access length in units |
| ale_no | output | 1 | Address-latch strobe, active low |
| oe_no | output | 1 | Read-enable strobe, active low |
| we_no | output | 1 | Write-enable strobe, active low |
| mclk_o | output | 1 | Memory clock |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
The checker asserts a set of properties on every cycle. It checks that the strobe not used by the access direction stays high and that the memory clock stays low outside synchronous accesses. It checks that done is a single-cycle pulse with every strobe released, and that an idle start clears the unit and phase counters. It also checks that the unit count moves only on a unit boundary. The exact placement of each strobe edge, the memory-clock duty pattern for each divider, the access length, the no-effect of mid-access field changes and the rejection of a start during an access are shown only by the bench. The bench compares every output, cycle by cycle, against a model of each scenario.

// File: rtl/mem_strobe_pkg.sv
package mem_strobe_pkg;
  localparam int NUM_STROBES = 3;

  typedef enum logic [1:0] {
    STB_ALE = 2'd0,
    STB_OE  = 2'd1,
    STB_WE  = 2'd2
  } strobe_e;
endpackage

// File: rtl/mst_unit_timer.sv
module mst_unit_timer #(
  parameter int TW = 5,
  parameter int DW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic          sync_i,
  input  logic [DW-1:0] ratio_m1_i,
  output logic [TW-1:0] unit_o,
  output logic [DW-1:0] phase_o,
  output logic          tick_o,
  output logic          mclk_o
);
  logic [TW-1:0] unit_q;
  logic [DW-1:0] phase_q;
  logic [DW:0]   half;

  assign tick_o = run_i && (phase_q == ratio_m1_i);
  // high span of a unit: ceil(ratio/2) = (ratio_m1 + 2) / 2
  assign half   = ({1'b0, ratio_m1_i} + (DW+1)'(2)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q  <= '0;
      phase_q <= '0;
    end else if (clear_i) begin
      unit_q  <= '0;
      phase_q <= '0;
    end else if (run_i) begin
      if (tick_o) begin
        phase_q <= '0;
        unit_q  <= unit_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!(run_i && sync_i))       mclk_o = 1'b0;
    else if (ratio_m1_i == '0)    mclk_o = clk_i;  // undivided: pass the clock through
    else                          mclk_o = ({1'b0, phase_q} < half);
  end

  assign unit_o  = unit_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/mst_strobe.sv
module mst_strobe #(
  parameter int TW = 5
) (
  input  logic          active_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] off_i,
  input  logic [TW-1:0] unit_i,
  output logic          strobe_no
);
  logic window;

  // empty window when off <= on
  assign window    = (on_i < off_i) && (unit_i >= on_i) && (unit_i < off_i);
  assign strobe_no = !(active_i && window);
endmodule

// File: rtl/mem_strobe_timer.sv
module mem_strobe_timer
  import mem_strobe_pkg::*;
#(
  parameter int TW = 5,
  parameter int DW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic          sync_i,
  input  logic [DW-1:0] div_i,
  input  logic [TW-1:0] ale_on_i,
  input  logic [TW-1:0] ale_off_i,
  input  logic [TW-1:0] oe_on_i,
  input  logic [TW-1:0] oe_off_i,
  input  logic [TW-1:0] we_on_i,
  input  logic [TW-1:0] we_off_i,
  input  logic [TW-1:0] cycle_i,
  output logic          ale_no,
  output logic          oe_no,
  output logic          we_no,
  output logic          mclk_o,
  output logic          done_o
);
  logic          busy_q, write_q, sync_q, done_q;
  logic [DW-1:0] div_q;
  logic [TW-1:0] cycle_q;
  logic [TW-1:0] on_q  [NUM_STROBES];
  logic [TW-1:0] off_q [NUM_STROBES];
  logic [NUM_STROBES-1:0] allow, stb_n;

  logic          accept, end_now, tick;
  logic [TW-1:0] unit;
  logic [DW-1:0] phase, ratio_m1;
  logic [TW:0]   unit_next;

  assign accept    = start_i && !busy_q;
  assign ratio_m1  = sync_q ? div_q : '0;
  assign unit_next = {1'b0, unit} + 1'b1;
  // cycle 0 behaves as 1
  assign end_now   = tick && (unit_next >= {1'b0, cycle_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
      end else if (end_now) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      sync_q  <= 1'b0;
      div_q   <= '0;
      cycle_q <= '0;
      for (int i = 0; i < NUM_STROBES; i++) begin
        on_q[i]  <= '0;
        off_q[i] <= '0;
      end
    end else if (accept) begin
      write_q              <= write_i;
      sync_q               <= sync_i;
      div_q                <= div_i;
      cycle_q              <= cycle_i;
      on_q[int'(STB_ALE)]  <= ale_on_i;
      off_q[int'(STB_ALE)] <= ale_off_i;
      on_q[int'(STB_OE)]   <= oe_on_i;
      off_q[int'(STB_OE)]  <= oe_off_i;
      on_q[int'(STB_WE)]   <= we_on_i;
      off_q[int'(STB_WE)]  <= we_off_i;
    end
  end

  mst_unit_timer #(.TW(TW), .DW(DW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .run_i     (busy_q),
    .sync_i    (sync_q),
    .ratio_m1_i(ratio_m1),
    .unit_o    (unit),
    .phase_o   (phase),
    .tick_o    (tick),
    .mclk_o    (mclk_o)
  );

  always_comb begin
    allow              = '0;
    allow[int'(STB_ALE)] = busy_q;
    allow[int'(STB_OE)]  = busy_q && !write_q;
    allow[int'(STB_WE)]  = busy_q && write_q;
  end

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
    mst_strobe #(.TW(TW)) u_stb (
      .active_i (allow[g]),
      .on_i     (on_q[g]),
      .off_i    (off_q[g]),
      .unit_i   (unit),
      .strobe_no(stb_n[g])
    );
  end

  assign ale_no = stb_n[int'(STB_ALE)];
  assign oe_no  = stb_n[int'(STB_OE)];
  assign we_no  = stb_n[int'(STB_WE)];
  assign done_o = done_q;
endmodule

// File: rtl/mem_strobe_timer_chk.sv
module mem_strobe_timer_chk #(
  parameter int TW = 5,
  parameter int DW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ale_no,
  input logic          oe_no,
  input logic          we_no,
  input logic          mclk_o,
  input logic          done_o,
  input logic          busy_q,
  input logic          write_q,
  input logic          sync_q,
  input logic          tick,
  input logic [TW-1:0] unit,
  input logic [DW-1:0] phase
);
  assert_read_no_we_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !write_q) |-> we_no);

  assert_write_no_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && write_q) |-> oe_no);

  assert_mclk_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q || !sync_q) |-> !mclk_o);

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (ale_no && oe_no && we_no && !mclk_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ale_no && oe_no && we_no && !busy_q));

  assert_start_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (busy_q && unit == '0 && phase == '0));

  assert_unit_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick && !start_i) |=> $stable(unit));
endmodule

bind mem_strobe_timer mem_strobe_timer_chk #(.TW(TW), .DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .ale_no (ale_no),
  .oe_no  (oe_no),
  .we_no  (we_no),
  .mclk_o (mclk_o),
  .done_o (done_o),
  .busy_q (busy_q),
  .write_q(write_q),
  .sync_q (sync_q),
  .tick   (tick),
  .unit   (unit),
  .phase  (phase)
);

// File: tb/mem_strobe_timer_test.sv
module mem_strobe_timer_test;
  localparam int TW = 5;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0, syn = 1'b0;
  logic [DW-1:0] div = '0;
  logic [TW-1:0] a_on = '0, a_off = '0, o_on = '0, o_off = '0, w_on = '0, w_off = '0, cyc = '0;
  logic ale_n, oe_n, we_n, mclk, done;

  int total_n = 0;
  int bad_n = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  mem_strobe_timer #(.TW(TW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr), .sync_i(syn), .div_i(div),
    .ale_on_i(a_on), .ale_off_i(a_off), .oe_on_i(o_on), .oe_off_i(o_off),
    .we_on_i(w_on), .we_off_i(w_off), .cycle_i(cyc),
    .ale_no(ale_n), .oe_no(oe_n), .we_no(we_n), .mclk_o(mclk), .done_o(done)
  );

  task automatic check(string req, string what, logic act, logic exp);
    total_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_strobe(bit allowed, int on, int off, int u);
    return !(allowed && on < off && u >= on && u < off);
  endfunction

  function automatic string stb_tag(bit s, bit allowed, int on, int off);
    if (!allowed) return "R8";
    if (off <= on) return "R7";
    return s ? "R5" : "R3";
  endfunction

  // disturb: change all fields and pulse start mid-access (R2, R10)
  task automatic run_access(bit w, bit s, int d, int aon, int aoff, int oon, int ooff,
                            int won, int woff, int c, bit disturb);
    int r, units, tot;
    r     = s ? d + 1 : 1;
    units = (c < 1) ? 1 : c;
    tot   = units * r;
    @(negedge clk);
    wr = w; syn = s; div = DW'(d); cyc = TW'(c);
    a_on = TW'(aon); a_off = TW'(aoff); o_on = TW'(oon); o_off = TW'(ooff);
    w_on = TW'(won); w_off = TW'(woff);
    start = 1'b1;
    for (int cnum = 0; cnum <= tot + 1; cnum++) begin
      @(posedge clk); #2;
      if (cnum < tot) begin
        int u, ph;
        u  = cnum / r;
        ph = cnum % r;
        check(disturb ? "R10" : stb_tag(s, 1, aon, aoff), "ale", ale_n, exp_strobe(1, aon, aoff, u));
        check(disturb ? "R10" : stb_tag(s, !w, oon, ooff), "oe", oe_n, exp_strobe(!w, oon, ooff, u));
        check(disturb ? "R2" : stb_tag(s, w, won, woff), "we", we_n, exp_strobe(w, won, woff, u));
        check(s ? "R6" : "R4", "mclk", mclk, s ? ((r == 1) ? 1'b1 : logic'(ph < (r + 1) / 2)) : 1'b0);
        check("R9", "done early", done, 1'b0);
      end else begin
        bit first = (cnum == tot);
        check("R9", "done", done, first);
        check(first ? "R9" : "R1", "strobes released", ale_n & oe_n & we_n, 1'b1);
        check(first ? "R9" : "R1", "mclk released", mclk, 1'b0);
      end
      @(negedge clk);
      start = (disturb && cnum == 0) ? 1'b1 : 1'b0;
      if (disturb && cnum == 0) begin
        wr = ~wr; syn = ~syn; div = div + 1'b1; cyc = cyc + TW'(3);
        a_on = TW'($urandom_range(0, 7)); a_off = TW'($urandom_range(0, 15));
        o_on = TW'($urandom_range(0, 7)); o_off = TW'($urandom_range(0, 15));
        w_on = TW'($urandom_range(0, 7)); w_off = TW'($urandom_range(0, 15));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    #3;
    check("R1", "reset ale", ale_n, 1'b1);
    check("R1", "reset oe", oe_n, 1'b1);
    check("R1", "reset we", we_n, 1'b1);
    check("R1", "reset mclk", mclk, 1'b0);
    check("R1", "reset done", done, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "idle strobes", ale_n & oe_n & we_n, 1'b1);

    // R3 R4 async read, divider ignored
    run_access(0, 0, 3, 0, 2, 1, 5, 0, 4, 7, 0);
    // R3 async write
    run_access(1, 0, 0, 1, 3, 0, 4, 2, 6, 8, 0);
    // R5 R6 synchronous, every divider
    run_access(0, 1, 1, 0, 1, 1, 4, 0, 3, 5, 0);
    run_access(1, 1, 0, 0, 2, 1, 3, 1, 4, 5, 0);
    run_access(1, 1, 2, 1, 2, 0, 3, 0, 3, 4, 0);
    run_access(0, 1, 3, 0, 2, 1, 3, 0, 1, 4, 0);
    // R7 off <= on
    run_access(0, 0, 0, 3, 3, 4, 2, 0, 5, 6, 0);
    // R9 cycle 0 and 1
    run_access(0, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0);
    run_access(1, 1, 1, 0, 1, 0, 1, 0, 1, 1, 0);
    // R2 R10 mid-access start and field changes
    run_access(0, 1, 1, 0, 2, 1, 5, 0, 3, 6, 1);
    run_access(1, 0, 0, 1, 4, 0, 2, 2, 6, 9, 1);

    for (int k = 0; k < 40; k++) begin
      run_access($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                 $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                 $urandom_range(0, 20), $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      bad_n++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end
endmodule